// File: doc/BRIEF.md
# Programmable Video Picture Adjustment

This block applies user picture controls to a 4:2:2 YCbCr sample stream. Each beat carries one luma sample and one chroma sample, and a phase flag tells whether the chroma sample is Cb or Cr. On luma it applies a three-tap horizontal peaking filter with sixteen gain steps, then contrast and brightness. On chroma it rotates the (Cb, Cr) offset vector by a hue angle that covers the whole circle in 256 steps, then scales the result by a saturation gain. All results are clamped to the nominal studio ranges.

The controls are level inputs. The block copies them into a snapshot only on the beat that carries the start-of-frame flag, so every frame uses one consistent set of settings. Every beat, valid or not, leaves the block exactly four clock cycles after it enters, with its valid and phase flags. The block is used inline between a decoder's sample output and its output formatter.

Top module: `vid_pic_adjust`

## Requirements
- R1: A beat presented before clock edge n appears at the outputs after edge n+3, so the latency is four cycles. `out_valid` and `out_cphase` are `in_valid` and `in_cphase` delayed by four cycles.
- R2: Output luma is floor((Ys-16)*K/128) + 16 + B. Ys is the sharpened luma, K is the unsigned contrast code (0x80 is unity) and B is the brightness code read as a signed 8-bit value.
- R3: Sharpened luma is Ys = Y + floor(G*(2Y-L-R)/32). L and R are the luma of the previous and next beats, and G is the 4-bit gain code. A neighbour whose valid is low is replaced by Y itself. Code 0 leaves luma unchanged.
- R4: Cb on a valid beat with phase 0 and Cr on the immediately following valid beat with phase 1 form a pair. With u=Cb-128 and v=Cr-128, the pair is rotated to u'=u*cos(a)-v*sin(a) and v'=u*sin(a)+v*cos(a), where a = hue code * 360/256 degrees. Hue code 0 is an exact identity.
- R5: Chroma output is floor(w*S/128) + 128, where w is the rotated offset and S is the unsigned saturation code (0x80 is unity).
- R6: A chroma sample that is not part of a pair gets no hue rotation. It still gets saturation and clamping.
- R7: On valid beats, output luma lies in 16..235 and output chroma lies in 16..240.
- R8: The controls are captured only on a beat with `in_valid` and `in_sof` high. They apply from that beat onward. Changes to the control inputs at any other time have no effect on the output.
- R9: After reset, `out_valid` is low. Until the first start-of-frame, the settings are brightness 0, contrast 0x80, hue 0, saturation 0x80 and gain 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat carries a sample |
| in_sof | input | 1 | Beat is the first of a frame; snapshot the controls |
| in_cphase | input | 1 | Chroma phase: 0 Cb, 1 Cr |
| in_y | input | 8 | Input luma |
| in_c | input | 8 | Input chroma |
| cfg_bright | input | 8 | Brightness offset, two's complement |
| cfg_contrast | input | 8 | Contrast gain, 0x80 unity |
| cfg_hue | input | 8 | Hue angle code, 360/256 degrees per step |
| cfg_sat | input | 8 | Saturation gain, 0x80 unity |
| cfg_sharp | input | 4 | Peaking gain code, 0 off |
| out_valid | output | 1 | Output beat carries a sample |
| out_cphase | output | 1 | Chroma phase of the output beat |
| out_y | output | 8 | Adjusted luma |
| out_c | output | 8 | Adjusted chroma |

## Verification
The embedded properties check on every cycle the things that hold at all times. These are the four-cycle alignment of the valid and phase flags, the output clamping ranges, that the active settings stay constant except on a start-of-frame, and that a pending chroma pair always meets its Cr sample. The arithmetic can only be shown by the bench's sweeps, which compare against values computed from the formulas. These sweeps cover contrast against brightness, all sixteen peaking gains with gaps in the valid stream, every hue code, every saturation code, unpaired chroma, and control changes in the middle of a frame.

// File: rtl/vid_pic_adjust.sv
module vid_pic_adjust (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_cphase,
  input  logic [7:0] in_y,
  input  logic [7:0] in_c,
  input  logic [7:0] cfg_bright,
  input  logic [7:0] cfg_contrast,
  input  logic [7:0] cfg_hue,
  input  logic [7:0] cfg_sat,
  input  logic [3:0] cfg_sharp,
  output logic       out_valid,
  output logic       out_cphase,
  output logic [7:0] out_y,
  output logic [7:0] out_c
);
  localparam logic [7:0] UNITY = 8'h80;

  // quarter-wave sine, Q8, k in 0..64 (k/64 of a right angle)
  function automatic logic signed [9:0] qsin(input logic [6:0] k);
    int unsigned t2, t4, inner, prod;
    t2    = 32'(k) * 32'(k);
    t4    = (t2 * t2) >> 12;
    inner = 32'd1646592 - 32'd165 * t2 + 32'd19 * t4;
    prod  = 32'(k) * inner;
    return 10'(prod >> 18);
  endfunction

  function automatic logic signed [9:0] trig(input logic [7:0] a);
    logic [6:0] k;
    logic signed [9:0] m;
    k = a[6] ? (7'd64 - {1'b0, a[5:0]}) : {1'b0, a[5:0]};
    m = qsin(k);
    return a[7] ? -m : m;
  endfunction

  // input taps: 0 newest, 1 centre, 2 oldest
  logic       v0, v1, v2, p0, p1, f0, f1;
  logic [7:0] y0, y1, y2, c0, c1;

  // settings: snapshot, then per-stage active copies
  logic [7:0] snap_bri, snap_con, snap_hue, snap_sat;
  logic [3:0] snap_gain;
  logic [7:0] mid_bri, mid_con, mid_sat;
  logic [7:0] act_hue;
  logic [3:0] act_gain;
  logic [7:0] act_bri, act_con, act_sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v0, v1, v2, p0, p1, f0, f1} <= '0;
      {y0, y1, y2, c0, c1} <= '0;
      snap_bri <= '0;  snap_con <= UNITY; snap_hue <= '0; snap_sat <= UNITY; snap_gain <= '0;
      mid_bri  <= '0;  mid_con  <= UNITY; mid_sat  <= UNITY;
      act_hue  <= '0;  act_gain <= '0;
      act_bri  <= '0;  act_con  <= UNITY; act_sat  <= UNITY;
    end else begin
      v0 <= in_valid; p0 <= in_cphase; f0 <= in_valid & in_sof; y0 <= in_y; c0 <= in_c;
      v1 <= v0; p1 <= p0; f1 <= f0; y1 <= y0; c1 <= c0;
      v2 <= v1; y2 <= y1;
      if (in_valid && in_sof) begin
        snap_bri  <= cfg_bright;
        snap_con  <= cfg_contrast;
        snap_hue  <= cfg_hue;
        snap_sat  <= cfg_sat;
        snap_gain <= cfg_sharp;
      end
      if (f0) begin
        act_hue  <= snap_hue;
        act_gain <= snap_gain;
        mid_bri  <= snap_bri;
        mid_con  <= snap_con;
        mid_sat  <= snap_sat;
      end
      if (f1) begin
        act_bri <= mid_bri;
        act_con <= mid_con;
        act_sat <= mid_sat;
      end
    end
  end

  // stage 2: luma peaking on the centre tap
  logic [7:0]         y_left, y_right;
  logic signed [10:0] hp, ysh;
  logic signed [15:0] hpg;

  assign y_left  = v2 ? y2 : y1;
  assign y_right = v0 ? y0 : y1;
  assign hp  = $signed({2'b0, y1, 1'b0}) - $signed({3'b0, y_left}) - $signed({3'b0, y_right});
  assign hpg = 16'(hp) * $signed({12'b0, act_gain});
  assign ysh = $signed({3'b0, y1}) + 11'(hpg >>> 5);

  // stage 2: hue rotation of a Cb (centre) / Cr (newest) pair
  logic signed [7:0]  u_c, v_c;
  logic signed [9:0]  sn, cs, ru, rv;
  logic signed [19:0] ru_w, rv_w;
  logic               pair;

  assign u_c  = $signed({~c1[7], c1[6:0]});
  assign v_c  = $signed({~c0[7], c0[6:0]});
  assign sn   = trig(act_hue);
  assign cs   = trig(act_hue + 8'd64);
  assign ru_w = 20'(u_c) * 20'(cs) - 20'(v_c) * 20'(sn);
  assign rv_w = 20'(u_c) * 20'(sn) + 20'(v_c) * 20'(cs);
  assign ru   = 10'(ru_w >>> 8);
  assign rv   = 10'(rv_w >>> 8);
  assign pair = v1 & ~p1 & v0 & p0;

  logic               s2v, s2p, pend;
  logic signed [10:0] s2y;
  logic signed [9:0]  s2c, held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2v <= 1'b0; s2p <= 1'b0; pend <= 1'b0;
      s2y <= '0;   s2c <= '0;   held <= '0;
    end else begin
      s2v  <= v1;
      s2p  <= p1;
      s2y  <= ysh;
      pend <= pair;
      if (pair) begin
        s2c  <= ru;
        held <= rv;
      end else if (pend) begin
        s2c  <= held;
      end else begin
        s2c  <= 10'(u_c);
      end
    end
  end

  // stage 3: contrast, brightness, saturation, clamping
  logic signed [11:0] yd;
  logic signed [20:0] ym;
  logic signed [13:0] yo;
  logic signed [18:0] cm;
  logic signed [11:0] co;
  logic [7:0]         y_fin, c_fin;

  assign yd = 12'(s2y) - 12'sd16;
  assign ym = 21'(yd) * $signed({13'b0, act_con});
  assign yo = 14'(ym >>> 7) + 14'sd16 + 14'($signed(act_bri));
  assign cm = 19'(s2c) * $signed({11'b0, act_sat});
  assign co = 12'(cm >>> 7) + 12'sd128;

  assign y_fin = (yo < 14'sd16) ? 8'd16 : (yo > 14'sd235) ? 8'd235 : yo[7:0];
  assign c_fin = (co < 12'sd16) ? 8'd16 : (co > 12'sd240) ? 8'd240 : co[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_cphase <= 1'b0;
      out_y      <= 8'd16;
      out_c      <= 8'd128;
    end else begin
      out_valid  <= s2v;
      out_cphase <= s2p;
      out_y      <= y_fin;
      out_c      <= c_fin;
    end
  end

  // cycles since reset, for the latency property
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n)            age <= '0;
    else if (age != 3'd7)  age <= age + 3'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 3'd5) |-> (out_valid == $past(in_valid, 4) && out_cphase == $past(in_cphase, 4)));

  assert_luma_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_y >= 8'd16 && out_y <= 8'd235));

  assert_chroma_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_c >= 8'd16 && out_c <= 8'd240));

  assert_hold_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !f0 |=> ($stable(act_hue) && $stable(act_gain)));

  assert_hold_late_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !f1 |=> ($stable(act_bri) && $stable(act_con) && $stable(act_sat)));

  assert_pair_meets_cr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (v1 && p1));
endmodule

// File: tb/vid_pic_adjust_test.sv
module vid_pic_adjust_test;
  localparam int PER  = 10;
  localparam int MAXN = 300;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_cphase = 1'b0;
  logic [7:0] in_y = '0, in_c = '0;
  logic [7:0] cfg_bright = '0, cfg_contrast = 8'h80, cfg_hue = '0, cfg_sat = 8'h80;
  logic [3:0] cfg_sharp = '0;
  logic       out_valid, out_cphase;
  logic [7:0] out_y, out_c;

  vid_pic_adjust uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_cphase(in_cphase),
    .in_y(in_y), .in_c(in_c), .cfg_bright(cfg_bright), .cfg_contrast(cfg_contrast),
    .cfg_hue(cfg_hue), .cfg_sat(cfg_sat), .cfg_sharp(cfg_sharp),
    .out_valid(out_valid), .out_cphase(out_cphase), .out_y(out_y), .out_c(out_c));

  always #(PER/2) clk = ~clk;

  int sv[MAXN], sy[MAXN], sc[MAXN], sp[MAXN], sf[MAXN];
  int kb[MAXN], kc[MAXN], kh[MAXN], ks[MAXN], kg[MAXN];
  int xb[MAXN], xc[MAXN], xh[MAXN], xs[MAXN], xg[MAXN];
  int ey[MAXN], ec[MAXN], et[MAXN];
  int n;
  int m_bri = 0, m_con = 128, m_hue = 0, m_sat = 128, m_gain = 0;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag_y = "R2", tag_c = "R5";

  function automatic int clampi(input int x, input int lo, input int hi);
    return (x < lo) ? lo : (x > hi) ? hi : x;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic fill_cfg(input int lo, input int hi, input int b, input int c, input int h, input int s, input int g);
    for (int i = lo; i < hi; i++) begin
      kb[i] = b; kc[i] = c; kh[i] = h; ks[i] = s; kg[i] = g;
    end
  endtask

  task automatic put(input int i, input int v, input int y, input int c, input int p, input int f);
    sv[i] = v; sy[i] = y; sc[i] = c; sp[i] = p; sf[i] = f;
  endtask

  function automatic int sat_out(input int w, input int s);
    return clampi(((w * s) >>> 7) + 128, 16, 240);
  endfunction

  task automatic build_expect();
    for (int i = 0; i < n; i++) begin
      if (sv[i] != 0 && sf[i] != 0) begin
        m_bri = kb[i]; m_con = kc[i]; m_hue = kh[i]; m_sat = ks[i]; m_gain = kg[i];
      end
      xb[i] = m_bri; xc[i] = m_con; xh[i] = m_hue; xs[i] = m_sat; xg[i] = m_gain;
    end
    for (int i = 0; i < n; i++) begin
      int l, r, hp, ys, br, u, v, h, cb_i;
      bit pcb, pcr;
      l  = (i > 0 && sv[i-1] != 0) ? sy[i-1] : sy[i];
      r  = (i + 1 < n && sv[i+1] != 0) ? sy[i+1] : sy[i];
      hp = 2 * sy[i] - l - r;
      ys = sy[i] + ((hp * xg[i]) >>> 5);
      br = (xb[i] >= 128) ? xb[i] - 256 : xb[i];
      ey[i] = clampi((((ys - 16) * xc[i]) >>> 7) + 16 + br, 16, 235);
      pcb = sv[i] != 0 && sp[i] == 0 && i + 1 < n && sv[i+1] != 0 && sp[i+1] == 1;
      pcr = i > 0 && sv[i-1] != 0 && sp[i-1] == 0 && sv[i] != 0 && sp[i] == 1;
      et[i] = 0;
      if (pcb || pcr) begin
        cb_i = pcb ? i : i - 1;
        u = sc[cb_i] - 128;
        v = sc[cb_i + 1] - 128;
        h = xh[cb_i];
        if (h == 0) begin
          ec[i] = sat_out(pcb ? u : v, xs[i]);
        end else begin
          real th, w;
          th = 2.0 * 3.14159265358979 * h / 256.0;
          w  = pcb ? (u * $cos(th) - v * $sin(th)) : (u * $sin(th) + v * $cos(th));
          ec[i] = clampi($rtoi($floor(w * xs[i] / 128.0)) + 128, 16, 240);
          et[i] = 3;
        end
      end else begin
        ec[i] = sat_out(sc[i] - 128, xs[i]);
      end
    end
  endtask

  task automatic compare(input int j);
    int ev, epp;
    ev  = (j < n) ? sv[j] : 0;
    epp = (j < n) ? sp[j] : 0;
    check("R1", "out_valid", int'(out_valid), ev, 0);
    if (ev != 0) begin
      check("R1", "out_cphase", int'(out_cphase), epp, 0);
      check(tag_y, "out_y", int'(out_y), ey[j], 0);
      check(tag_c, "out_c", int'(out_c), ec[j], et[j]);
    end
  endtask

  task automatic drive(input int k);
    if (k < n) begin
      in_valid = sv[k][0]; in_sof = sf[k][0]; in_cphase = sp[k][0];
      in_y = 8'(sy[k]); in_c = 8'(sc[k]);
      cfg_bright = 8'(kb[k]); cfg_contrast = 8'(kc[k]); cfg_hue = 8'(kh[k]);
      cfg_sat = 8'(ks[k]); cfg_sharp = 4'(kg[k]);
    end else begin
      in_valid = 1'b0; in_sof = 1'b0;
    end
  endtask

  task automatic run();
    build_expect();
    for (int k = 0; k < n + 5; k++) begin
      @(negedge clk);
      if (k >= 4) compare(k - 4);
      drive(k);
    end
  endtask

  function automatic int vec_cb(input int j);
    return 128 + ((j * 37) % 225) - 112;
  endfunction
  function automatic int vec_cr(input int j);
    return 128 + ((j * 53 + 11) % 225) - 112;
  endfunction

  initial begin
    #(PER * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // R9: reset holds the outputs idle even with valid input
    in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9", "out_valid in reset", int'(out_valid), 0, 0);
    end
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) @(negedge clk);
    check("R9", "out_valid after reset", int'(out_valid), 0, 0);

    // R9/R8: no start-of-frame, so odd control values must be ignored
    n = 256;
    for (int i = 0; i < n; i++) put(i, 1, i, i, i % 2, 0);
    fill_cfg(0, n, 8'h40, 8'h20, 8'h33, 8'h10, 9);
    tag_y = "R9"; tag_c = "R9";
    run();

    // R2/R7: contrast against brightness over the whole luma range
    tag_y = "R2"; tag_c = "R7";
    foreach (sv[i]) ;
    for (int ci = 0; ci < 5; ci++) begin
      for (int bi = 0; bi < 5; bi++) begin
        int cons[5], bris[5];
        cons = '{0, 64, 128, 192, 255};
        bris = '{0, 32, 224, 127, 128};
        n = 256;
        for (int i = 0; i < n; i++) put(i, 1, i, (i * 7) % 256, i % 2, (i == 0) ? 1 : 0);
        fill_cfg(0, n, bris[bi], cons[ci], 0, 128, 0);
        run();
      end
    end

    // R3: every peaking gain, with gaps that force neighbour replication
    tag_y = "R3"; tag_c = "R5";
    for (int g = 0; g < 16; g++) begin
      n = 64;
      for (int i = 0; i < n; i++)
        put(i, (i % 16 == 15) ? 0 : 1, ((i % 8) < 4) ? 40 : 200 - (i % 5) * 30, 128, i % 2, (i == 0) ? 1 : 0);
      sy[20] = 255; sy[33] = 0;
      fill_cfg(0, n, 0, 128, 0, 128, g);
      run();
    end

    // R4: every hue code on sixteen chroma pairs
    tag_y = "R2"; tag_c = "R4";
    for (int h = 0; h < 256; h++) begin
      n = 32;
      for (int j = 0; j < 16; j++) begin
        put(2 * j,     1, 100, vec_cb(j + h), 0, (j == 0) ? 1 : 0);
        put(2 * j + 1, 1, 100, vec_cr(j + h), 1, 0);
      end
      fill_cfg(0, n, 0, 128, h, 128, 0);
      run();
    end

    // R5: every saturation code, hue zero
    tag_c = "R5";
    for (int s = 0; s < 256; s++) begin
      n = 32;
      for (int j = 0; j < 16; j++) begin
        put(2 * j,     1, 90, vec_cb(j + s), 0, (j == 0) ? 1 : 0);
        put(2 * j + 1, 1, 90, vec_cr(j + s), 1, 0);
      end
      fill_cfg(0, n, 0, 128, 0, s, 0);
      run();
    end

    // R6: unpaired chroma gets no rotation
    tag_c = "R6";
    n = 8;
    put(0, 1, 80, 40,  0, 1);
    put(1, 0, 80, 63,  0, 0);
    put(2, 1, 80, 86,  1, 0);
    put(3, 1, 80, 109, 0, 0);
    put(4, 1, 80, 132, 0, 0);
    put(5, 1, 80, 220, 1, 0);
    put(6, 1, 80, 20,  1, 0);
    put(7, 1, 80, 200, 0, 0);
    fill_cfg(0, n, 0, 128, 8'h40, 8'h90, 0);
    run();

    // R8: controls change mid-frame without start-of-frame, then a new frame
    tag_y = "R8"; tag_c = "R8";
    n = 200;
    for (int i = 0; i < n; i++)
      put(i, 1, (i * 13) % 256, (i * 29) % 256, i % 2, (i == 0 || i == 150) ? 1 : 0);
    fill_cfg(0, 100, 16, 160, 0, 100, 4);
    fill_cfg(100, 150, 200, 40, 8'h55, 250, 15);
    fill_cfg(150, n, 240, 96, 0, 180, 11);
    run();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule